// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between a set of interrupt sources and a processor's interrupt request line. For each source it receives a pending bit, an enable bit, a three-bit urgency level and a handler address. The enabled pending sources compete combinationally for the line. A competitor qualifies only if its level is strictly above the level now being serviced. With nothing in service, every enabled request qualifies. The line is active low.

Software takes an interrupt by reading the vector port. The block then does four things:
- It registers the winner's handler address.
- It sends a one-cycle acknowledge pulse to that source.
- It pushes the winner's level and index as the new in-service context.
- It releases the line unless something still more urgent is waiting.

An end-of-interrupt write pops the context and brings back the interrupted one. If a waiting request ranks above the restored level, the line drops low again.

A read that finds nothing qualifying returns a programmable spurious vector. A read that would nest deeper than the context storage allows also returns that vector. An end-of-interrupt with nothing in service has no effect on the contexts. Both misuse cases, the overflowing read and the empty end-of-interrupt, set a sticky error flag.

Top module: `nest_irq_arb`

## Requirements
- R1: After reset, irq_n is 1 with no request pending, vec_data is 0, src_ack is 0, depth is 0, cur_lvl and cur_src are 0, and stk_err is 0.
- R2: With depth 0, any source i with src_pend[i] and src_en[i] both 1 drives irq_n to 0 in the same cycle, whatever its level. A source with src_en[i]=0 is ignored.
- R3: The level of source i is src_prio[3i+2:3i], and a larger value is more urgent. Among enabled pending sources the winner has the largest level, and ties go to the lowest index. After a qualifying vec_rd, vec_data holds the winner's slice src_vec[VW*i +: VW] from the next cycle on, and keeps it until the next vec_rd.
- R4: A qualifying vec_rd gives src_ack a one-hot pulse on the winner's bit for exactly the next cycle, increments depth, and sets cur_lvl and cur_src to the winner. Without vec_rd, src_ack stays 0.
- R5: While depth is nonzero, irq_n is 0 only if the winner's level is strictly greater than cur_lvl. Equal or lower levels leave it at 1.
- R6: An eoi_wr with depth nonzero decrements depth and restores cur_lvl and cur_src to the interrupted context. irq_n then follows R5 against the restored level.
- R7: A vec_rd with no qualifying request loads spur_vec into vec_data, gives no acknowledge, and leaves depth unchanged.
- R8: A qualifying vec_rd when depth equals DEPTH loads spur_vec into vec_data, gives no acknowledge, leaves depth unchanged, and sets stk_err.
- R9: An eoi_wr with depth 0 leaves depth at 0 and sets stk_err. stk_err stays 1 until reset.
- R10: When vec_rd and eoi_wr are both 1 in the same cycle, only the read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | NSRC | Pending request per source |
| src_en | input | NSRC | Enable per source |
| src_prio | input | NSRC*LW | Level per source, LW bits each |
| src_vec | input | NSRC*VW | Handler address per source, VW bits each |
| spur_vec | input | VW | Value returned by a read that takes no interrupt |
| vec_rd | input | 1 | Vector read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| irq_n | output | 1 | Interrupt request line, active low |
| vec_data | output | VW | Vector captured at the last read |
| src_ack | output | NSRC | One-cycle acknowledge to the taken source |
| cur_lvl | output | LW | Level in service (0 when idle) |
| cur_src | output | SW | Source in service (0 when idle) |
| depth | output | DW | Number of nested contexts |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the arbiter with NSRC=8, VW=16 and DEPTH=4. With four context slots but eight levels, a fifth strictly increasing nest is possible, so the overflow path of R8 can actually be reached. At the default depth of eight that path cannot be reached by legal preemption. Eight sources keep tie cases and disabled high-level requests frequent under random stimulus, and the short stack makes full and empty boundaries come up often.

// File: rtl/nest_irq_arb.sv
module nest_irq_arb #(
  parameter int NSRC  = 32,
  parameter int LW    = 3,
  parameter int VW    = 32,
  parameter int DEPTH = 8,
  localparam int SW = $clog2(NSRC),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_pend,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC*LW-1:0] src_prio,
  input  logic [NSRC*VW-1:0] src_vec,
  input  logic [VW-1:0]     spur_vec,
  input  logic              vec_rd,
  input  logic              eoi_wr,
  output logic              irq_n,
  output logic [VW-1:0]     vec_data,
  output logic [NSRC-1:0]   src_ack,
  output logic [LW-1:0]     cur_lvl,
  output logic [SW-1:0]     cur_src,
  output logic [DW-1:0]     depth,
  output logic              stk_err
);

  logic [LW-1:0] stk_lvl [DEPTH];
  logic [SW-1:0] stk_src [DEPTH];
  logic [DW-1:0] sp;
  logic          win_v, qual, full;
  logic [SW-1:0] win_i;
  logic [LW-1:0] win_p;
  logic [NSRC-1:0] req;

  assign req   = src_pend & src_en;
  assign depth = sp;
  assign full  = (sp == DW'(DEPTH));

  always_comb begin
    win_v = 1'b0;
    win_i = '0;
    win_p = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!win_v || src_prio[i*LW +: LW] > win_p)) begin
        win_v = 1'b1;
        win_i = SW'(i);
        win_p = src_prio[i*LW +: LW];
      end
    end
  end

  always_comb begin
    cur_lvl = '0;
    cur_src = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == DW'(i + 1)) begin
        cur_lvl = stk_lvl[i];
        cur_src = stk_src[i];
      end
    end
  end

  assign qual  = win_v && (sp == '0 || win_p > cur_lvl);
  assign irq_n = ~qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        stk_lvl[i] <= '0;
        stk_src[i] <= '0;
      end
    end else if (vec_rd && qual && !full) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sp == DW'(i)) begin
          stk_lvl[i] <= win_p;
          stk_src[i] <= win_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_data <= '0;
      src_ack  <= '0;
      sp       <= '0;
      stk_err  <= 1'b0;
    end else begin
      src_ack <= '0;
      if (vec_rd) begin
        if (qual && !full) begin
          vec_data <= src_vec[win_i*VW +: VW];
          src_ack  <= NSRC'(1) << win_i;
          sp       <= sp + DW'(1);
        end else begin
          vec_data <= spur_vec;
          if (qual) stk_err <= 1'b1;
        end
      end else if (eoi_wr) begin
        if (sp == '0) stk_err <= 1'b1;
        else          sp <= sp - DW'(1);
      end
    end
  end

endmodule

module nest_irq_arb_chk #(
  parameter int NSRC  = 32,
  parameter int LW    = 3,
  parameter int DEPTH = 8,
  parameter int SW    = 5,
  parameter int DW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_rd,
  input logic            eoi_wr,
  input logic            irq_n,
  input logic [NSRC-1:0] src_ack,
  input logic [LW-1:0]   cur_lvl,
  input logic [DW-1:0]   depth,
  input logic            stk_err
);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack)); // R4

  AST_ACK_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> $past(vec_rd)); // R4

  AST_NO_ACK_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_n) |=> (src_ack == '0)); // R7

  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> ($past(depth) == '0 || cur_lvl > $past(cur_lvl))); // R5

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !vec_rd && depth != '0) |=> (depth == $past(depth) - DW'(1))); // R6

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err); // R9

endmodule

bind nest_irq_arb nest_irq_arb_chk #(
  .NSRC(NSRC), .LW(LW), .DEPTH(DEPTH), .SW(SW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd), .eoi_wr(eoi_wr), .irq_n(irq_n),
  .src_ack(src_ack), .cur_lvl(cur_lvl), .depth(depth), .stk_err(stk_err)
);

// File: tb/sim_nest_irq_arb.sv
module sim_nest_irq_arb;
  localparam int NSRC = 8, LW = 3, VW = 16, DEPTH = 4, SW = 3, DW = 3;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_pend = '0, src_en = '1;
  logic [NSRC*LW-1:0] src_prio;
  logic [NSRC*VW-1:0] src_vec;
  logic [VW-1:0] spur_vec = 16'hDEAD;
  logic vec_rd = 0, eoi_wr = 0;
  logic irq_n, stk_err;
  logic [VW-1:0] vec_data;
  logic [NSRC-1:0] src_ack;
  logic [LW-1:0] cur_lvl;
  logic [SW-1:0] cur_src;
  logic [DW-1:0] depth;

  logic [LW-1:0] prio_a [NSRC];
  logic [VW-1:0] vec_a [NSRC];
  int checks = 0, fails = 0;
  bit done = 0;
  int m_sp = 0;
  int m_lvl [DEPTH];
  int m_src [DEPTH];
  bit m_err = 0;
  logic [VW-1:0] e_vec = '0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NSRC; i++) begin
      src_prio[i*LW +: LW] = prio_a[i];
      src_vec[i*VW +: VW]  = vec_a[i];
    end

  nest_irq_arb #(.NSRC(NSRC), .LW(LW), .VW(VW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .src_prio(src_prio), .src_vec(src_vec), .spur_vec(spur_vec),
    .vec_rd(vec_rd), .eoi_wr(eoi_wr), .irq_n(irq_n), .vec_data(vec_data),
    .src_ack(src_ack), .cur_lvl(cur_lvl), .cur_src(cur_src),
    .depth(depth), .stk_err(stk_err));

  task automatic chk(input string t, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, a, e, $time);
    end
  endtask

  function automatic void ref_win(output bit v, output int w, output int p);
    v = 0; w = 0; p = -1;
    for (int i = 0; i < NSRC; i++)
      if (src_pend[i] && src_en[i] && int'(prio_a[i]) > p) begin
        v = 1; w = i; p = int'(prio_a[i]);
      end
  endfunction

  int last_w;
  bit last_ack;

  task automatic step(input bit rd, input bit eo);
    bit v, q;
    int w, p, top;
    string tag;
    logic [NSRC-1:0] e_ack;
    vec_rd = rd; eoi_wr = eo;
    #1;
    ref_win(v, w, p);
    top = (m_sp == 0) ? -1 : m_lvl[m_sp-1];
    q = v && (p > top);
    chk(m_sp != 0 ? "R5" : "R2", irq_n, !q);
    e_ack = '0;
    last_ack = 0;
    if (rd) begin
      if (q && m_sp < DEPTH) begin
        m_lvl[m_sp] = p; m_src[m_sp] = w; m_sp++;
        e_vec = vec_a[w]; e_ack = NSRC'(1) << w;
        last_w = w; last_ack = 1;
        tag = eo ? "R10" : "R3";
      end else begin
        e_vec = spur_vec;
        if (q) begin m_err = 1; tag = "R8"; end
        else tag = eo ? "R10" : "R7";
      end
    end else if (eo) begin
      if (m_sp == 0) begin m_err = 1; tag = "R9"; end
      else begin m_sp--; tag = "R6"; end
    end else tag = "R4";
    @(posedge clk); #1;
    vec_rd = 0; eoi_wr = 0;
    chk(tag, vec_data, e_vec);
    chk("R4", src_ack, e_ack);
    chk(tag, depth, m_sp);
    chk(tag, stk_err, m_err);
    chk(tag, cur_lvl, m_sp != 0 ? m_lvl[m_sp-1] : 0);
    chk(tag, cur_src, m_sp != 0 ? m_src[m_sp-1] : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    prio_a = '{3'd3, 3'd5, 3'd4, 3'd1, 3'd7, 3'd4, 3'd2, 3'd0};
    for (int i = 0; i < NSRC; i++) vec_a[i] = 16'h1000 + VW'(i * 16'h0111);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", irq_n, 1); chk("R1", vec_data, 0); chk("R1", src_ack, 0);
    chk("R1", depth, 0); chk("R1", stk_err, 0); chk("R1", cur_lvl, 0); chk("R1", cur_src, 0);
    rst_n = 1;
    @(posedge clk); #1;

    src_pend = 8'h80; step(0, 0);        // R2: level 0 alone asserts
    step(1, 0); step(0, 0);              // R5: equal level does not reassert
    src_pend = 8'hB4; src_en = 8'hEF;    // R3: src2/src5 tie, src4 disabled
    step(0, 0); step(1, 0); step(0, 0);
    src_en = 8'hFF; step(1, 0);          // nested level 7
    step(0, 1); step(0, 1); step(0, 0);  // R6 pops and reassert
    step(0, 1); step(0, 1); step(0, 1);  // R9 underflow
    src_pend = 8'h80; step(1, 0);
    src_pend = 8'h88; step(1, 0);
    src_pend = 8'hC8; step(1, 0);
    src_pend = 8'hC9; step(1, 0);
    src_pend = 8'hCD; step(1, 0);        // R8 overflow
    step(0, 1); step(1, 1);              // R10 read wins
    src_pend = 8'h00; step(1, 0);        // R7 spurious
    repeat (5) step(0, 1);

    for (int n = 0; n < 4000; n++) begin
      int op;
      if ($urandom % 4 == 0) src_pend = src_pend ^ NSRC'($urandom);
      if ($urandom % 16 == 0) src_en = NSRC'($urandom) | NSRC'($urandom);
      if ($urandom % 64 == 0) prio_a[$urandom % NSRC] = LW'($urandom);
      op = $urandom % 10;
      if (op < 4) step(1, 0);
      else if (op < 7) step(0, 1);
      else if (op < 8) step(1, 1);
      else step(0, 0);
      if (last_ack && $urandom % 2 == 0) src_pend[last_w] = 1'b0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule